// File: doc/BRIEF.md
# Page Slot Router

The router sits behind a decoder that has already matched one 4 KiB page of the address space. It cuts that page into 16 slots of 256 bytes each. A table with one entry per slot records which of several downstream device ports serves the slot. Each access first has the page base subtracted. Bits 11:8 of the resulting page-relative address then pick a table entry. The read or write goes out on the port that entry names, together with the full page-relative address, the access size and the write data. The port's read data comes back to the initiator as a single-cycle response.

The table is filled at run time through a configuration port. A request gives a byte offset, a byte length and a target number, and the router binds every slot that the byte range touches, one slot per clock. A target number equal to the device count stands for the unassigned sink. Every slot points at this sink after reset. The sink answers reads with zero and drops writes without touching any device port. A request is refused, with a one-cycle error pulse, when its range runs past the end of the page or its target number is larger than the device count.

Top module: `page_slot_router`

## Requirements
- R1: After reset `cfg_ready` and `req_ready` are 1, `rsp_valid`, `cfg_error` and every `dev_valid` bit are 0, and every slot is bound to the unassigned sink.
- R2: An accepted access to address A goes to the target bound to slot ((A − PAGE_BASE) >> 8) mod 16. From the cycle after acceptance, only that target's `dev_valid` bit is high.
- R3: The device port receives `dev_offset` = (A − PAGE_BASE) mod 4096, the full page-relative address and not the offset inside the slot. It also receives the access size unchanged (0 = byte, 1 = halfword, 2 = word), the write flag and the write data.
- R4: A registration with offset O, length L > 0 and target T binds every slot from O >> 8 through (O + L − 1) >> 8 inclusive to T. All other slots keep their binding.
- R5: A registration is refused when O + L > 4096 or T > 4 (the device count). `cfg_error` is then 1 for exactly the cycle after acceptance and the table does not change. O + L = 4096 is accepted.
- R6: A registration with L = 0 is accepted without error and changes no slot.
- R7: Target number 4 in a registration returns the covered slots to the unassigned sink.
- R8: An access to an unassigned slot raises no `dev_valid` bit. `rsp_valid` is 1 in the cycle after acceptance with `rsp_rdata` = 0, and a write is discarded.
- R9: After an accepted registration, `cfg_ready` stays 0 for exactly as many cycles as there are slots to bind, and `req_ready` is 0 for all of those cycles.
- R10: Only one access is in flight at a time. From acceptance until the response, `req_ready` is 0 and `dev_valid`, `dev_offset` and `dev_size` hold still until the device raises its `dev_ack` bit. `rsp_valid` is 1 in the cycle after the edge that samples the ack. `rsp_rdata` then carries the device's read data for a read and 0 for a write.
- R11: While the router is idle and `cfg_valid` is 1, `req_ready` is 0, so a registration wins over a simultaneous access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Registration request |
| cfg_ready | output | 1 | Router can accept a registration |
| cfg_offset | input | 12 | Page-relative start byte of the range |
| cfg_length | input | 13 | Byte length of the range |
| cfg_target | input | 3 | Target number, 4 = unassigned sink |
| cfg_error | output | 1 | One-cycle pulse on a refused registration |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Router can accept an access |
| req_addr | input | 32 | Access address inside the page |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Access response pulse |
| rsp_rdata | output | 32 | Read data, 0 for writes and the sink |
| dev_valid | output | 4 | Per-target request, held until ack |
| dev_write | output | 1 | Forwarded write flag |
| dev_offset | output | 12 | Forwarded page-relative address |
| dev_size | output | 2 | Forwarded access size |
| dev_wdata | output | 32 | Forwarded write data |
| dev_ack | input | 4 | Per-target completion |
| dev_rdata | input | 128 | Per-target read data, target i in bits 32i+31:32i |

## Verification
The hardest cases to reach from the ports are the slot edges. One is a registration whose byte range crosses a 256-byte boundary by only a few bytes. The other is one that ends exactly at the top of the page and must be accepted, while one byte more must be refused. Directed registrations hit these edges, and accesses then probe the first and last byte of each affected slot and the slot next to it. Random registrations with lengths that often run past the page, and random target numbers that include the sink and illegal values, are interleaved with random accesses. Between these, the device models stall for random numbers of cycles, so that overwrites, unbinding and refusals meet a table already holding earlier bindings.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic { WK_IDLE = 1'b0, WK_RUN = 1'b1 } walk_state_e;
  typedef enum logic { AX_IDLE = 1'b0, AX_DEV = 1'b1 } acc_state_e;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/psr_cfg_walker.sv
module psr_cfg_walker
  import psr_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int SLOT_BITS = 8,
  parameter int N_TGT     = 4,
  parameter int IDX_W     = 4,
  parameter int TGT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic [PAGE_BITS-1:0] cfg_offset,
  input  logic [PAGE_BITS:0]   cfg_length,
  input  logic [TGT_W-1:0]     cfg_target,
  output logic                 cfg_ready,
  output logic                 cfg_error,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [TGT_W-1:0]     wr_tgt
);
  localparam int SUM_W     = PAGE_BITS + 2;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  walk_state_e      state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d, last_q, last_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             err_q, err_d;
  logic             ptr_en;

  logic [SUM_W-1:0] span_end, last_byte;
  logic             over_page, bad_tgt, accept;
  logic [IDX_W-1:0] first_idx, last_idx;

  assign span_end  = {2'b00, cfg_offset} + {1'b0, cfg_length};
  assign last_byte = span_end - SUM_W'(1);
  assign over_page = span_end > SUM_W'(PAGE_SIZE);
  assign bad_tgt   = cfg_target > TGT_W'(N_TGT);
  assign first_idx = cfg_offset[PAGE_BITS-1:SLOT_BITS];
  assign last_idx  = last_byte[PAGE_BITS-1:SLOT_BITS];
  assign accept    = cfg_valid && (state_q == WK_IDLE);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    tgt_d   = tgt_q;
    err_d   = 1'b0;
    ptr_en  = 1'b0;
    unique case (state_q)
      WK_IDLE: begin
        if (accept) begin
          if (over_page || bad_tgt) begin
            err_d = 1'b1;
          end else if (cfg_length != '0) begin
            state_d = WK_RUN;
            cur_d   = first_idx;
            last_d  = last_idx;
            tgt_d   = cfg_target;
            ptr_en  = 1'b1;
          end
        end
      end
      WK_RUN: begin
        ptr_en = 1'b1;
        if (cur_q == last_q) state_d = WK_IDLE;
        else                 cur_d   = cur_q + IDX_W'(1);
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
      tgt_q  <= '0;
    end else if (ptr_en) begin
      cur_q  <= cur_d;
      last_q <= last_d;
      tgt_q  <= tgt_d;
    end
  end

  assign cfg_ready = (state_q == WK_IDLE);
  assign cfg_error = err_q;
  assign wr_en     = (state_q == WK_RUN);
  assign wr_idx    = cur_q;
  assign wr_tgt    = tgt_q;
endmodule

// File: rtl/psr_slot_table.sv
module psr_slot_table #(
  parameter int NSLOT  = 16,
  parameter int IDX_W  = 4,
  parameter int TGT_W  = 3,
  parameter int SINK_ID = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TGT_W-1:0] rd_tgt
);
  logic [NSLOT*TGT_W-1:0] tbl_flat;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [TGT_W-1:0] ent_q;
    logic             ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= TGT_W'(SINK_ID);
      else if (ent_en) ent_q <= wr_tgt;
    end
    assign tbl_flat[g*TGT_W +: TGT_W] = ent_q;
  end

  assign rd_tgt = tbl_flat[rd_idx*TGT_W +: TGT_W];
endmodule

// File: rtl/psr_access_ctrl.sv
module psr_access_ctrl
  import psr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PAGE_BITS = 12,
  parameter int                SLOT_BITS = 8,
  parameter int                N_TGT     = 4,
  parameter int                IDX_W     = 4,
  parameter int                TGT_W     = 3,
  parameter logic [ADDR_W-1:0] PAGE_BASE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic                    walk_idle,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic [IDX_W-1:0]        look_idx,
  input  logic [TGT_W-1:0]        look_tgt,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [N_TGT-1:0]        dev_valid,
  output logic                    dev_write,
  output logic [PAGE_BITS-1:0]    dev_offset,
  output logic [1:0]              dev_size,
  output logic [DATA_W-1:0]       dev_wdata,
  input  logic [N_TGT-1:0]        dev_ack,
  input  logic [N_TGT*DATA_W-1:0] dev_rdata
);
  acc_state_e          state_q, state_d;
  logic [TGT_W-1:0]    tgt_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [1:0]          size_q;
  logic                write_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0]   rsp_d_q, rsp_d_d;
  logic                rsp_en, lat_en;

  logic [ADDR_W-1:0]   rel_addr;
  logic [PAGE_BITS-1:0] rel_off;
  logic                accept, to_sink, ack_hit;
  logic [DATA_W-1:0]   sel_rdata;

  assign rel_addr  = req_addr - PAGE_BASE;
  assign rel_off   = rel_addr[PAGE_BITS-1:0];
  assign look_idx  = rel_off[PAGE_BITS-1:SLOT_BITS];
  assign to_sink   = look_tgt >= TGT_W'(N_TGT);
  assign req_ready = (state_q == AX_IDLE) && walk_idle && !cfg_valid;
  assign accept    = req_valid && req_ready;
  assign ack_hit   = |(dev_ack & dev_valid);

  always_comb begin
    sel_rdata = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (tgt_q == TGT_W'(i)) sel_rdata = dev_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    state_d = state_q;
    rsp_v_d = 1'b0;
    rsp_d_d = rsp_d_q;
    rsp_en  = 1'b0;
    lat_en  = 1'b0;
    unique case (state_q)
      AX_IDLE: begin
        if (accept) begin
          lat_en = 1'b1;
          if (to_sink) begin
            rsp_v_d = 1'b1;
            rsp_d_d = '0;
            rsp_en  = 1'b1;
          end else begin
            state_d = AX_DEV;
          end
        end
      end
      AX_DEV: begin
        if (ack_hit) begin
          state_d = AX_IDLE;
          rsp_v_d = 1'b1;
          rsp_d_d = write_q ? '0 : sel_rdata;
          rsp_en  = 1'b1;
        end
      end
      default: state_d = AX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AX_IDLE;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_d_q <= '0;
    else if (rsp_en) rsp_d_q <= rsp_d_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (lat_en) begin
      tgt_q   <= look_tgt;
      off_q   <= rel_off;
      size_q  <= req_size;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  for (genvar i = 0; i < N_TGT; i++) begin : g_port
    assign dev_valid[i] = (state_q == AX_DEV) && (tgt_q == TGT_W'(i));
  end

  assign dev_write  = write_q;
  assign dev_offset = off_q;
  assign dev_size   = size_q;
  assign dev_wdata  = wdata_q;
  assign rsp_valid  = rsp_v_q;
  assign rsp_rdata  = rsp_d_q;
endmodule

// File: rtl/page_slot_router.sv
module page_slot_router #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PAGE_BITS = 12,
  parameter int                SLOT_BITS = 8,
  parameter int                N_TGT     = 4,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 32'h4000_3000,
  localparam int               IDX_W     = PAGE_BITS - SLOT_BITS,
  localparam int               NSLOT     = 1 << IDX_W,
  localparam int               TGT_W     = $clog2(N_TGT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  output logic                    cfg_ready,
  input  logic [PAGE_BITS-1:0]    cfg_offset,
  input  logic [PAGE_BITS:0]      cfg_length,
  input  logic [TGT_W-1:0]        cfg_target,
  output logic                    cfg_error,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [N_TGT-1:0]        dev_valid,
  output logic                    dev_write,
  output logic [PAGE_BITS-1:0]    dev_offset,
  output logic [1:0]              dev_size,
  output logic [DATA_W-1:0]       dev_wdata,
  input  logic [N_TGT-1:0]        dev_ack,
  input  logic [N_TGT*DATA_W-1:0] dev_rdata
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, look_idx;
  logic [TGT_W-1:0] wr_tgt, look_tgt;

  psr_cfg_walker #(
    .PAGE_BITS(PAGE_BITS), .SLOT_BITS(SLOT_BITS), .N_TGT(N_TGT),
    .IDX_W(IDX_W), .TGT_W(TGT_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_offset(cfg_offset), .cfg_length(cfg_length),
    .cfg_target(cfg_target), .cfg_ready(cfg_ready), .cfg_error(cfg_error),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tgt(wr_tgt)
  );

  psr_slot_table #(
    .NSLOT(NSLOT), .IDX_W(IDX_W), .TGT_W(TGT_W), .SINK_ID(N_TGT)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tgt(wr_tgt),
    .rd_idx(look_idx), .rd_tgt(look_tgt)
  );

  psr_access_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
    .SLOT_BITS(SLOT_BITS), .N_TGT(N_TGT), .IDX_W(IDX_W), .TGT_W(TGT_W),
    .PAGE_BASE(PAGE_BASE)
  ) u_acc (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .walk_idle(cfg_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .look_idx(look_idx), .look_tgt(look_tgt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_valid(dev_valid), .dev_write(dev_write), .dev_offset(dev_offset),
    .dev_size(dev_size), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int PAGE_BITS = 12,
  parameter int N_TGT     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_valid,
  input logic                 cfg_ready,
  input logic                 cfg_error,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic [N_TGT-1:0]     dev_valid,
  input logic [PAGE_BITS-1:0] dev_offset,
  input logic [1:0]           dev_size,
  input logic [N_TGT-1:0]     dev_ack
);
  p_dev_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_valid));

  p_err_after_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> $past(cfg_valid && cfg_ready));

  p_walk_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> !req_ready);

  p_dev_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dev_valid & ~dev_ack)) |=>
      ($stable(dev_valid) && $stable(dev_offset) && $stable(dev_size)));

  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_valid) |-> !req_ready);

  p_cfg_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !req_ready);

  p_rsp_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(|(dev_valid & dev_ack))));
endmodule

bind page_slot_router psr_checker #(.PAGE_BITS(PAGE_BITS), .N_TGT(N_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_error(cfg_error), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .dev_valid(dev_valid), .dev_offset(dev_offset),
  .dev_size(dev_size), .dev_ack(dev_ack)
);

// File: tb/page_slot_router_test.sv
`timescale 1ns/1ps
module page_slot_router_test;
  localparam logic [31:0] BASE = 32'h4000_3000;
  localparam int SINK = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_valid, cfg_ready, cfg_error;
  logic [11:0]  cfg_offset;
  logic [12:0]  cfg_length;
  logic [2:0]   cfg_target;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr, req_wdata;
  logic [1:0]   req_size;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [3:0]   dev_valid, dev_ack;
  logic         dev_write;
  logic [11:0]  dev_offset;
  logic [1:0]   dev_size;
  logic [31:0]  dev_wdata;
  logic [127:0] dev_rdata;

  int checks = 0;
  int errors = 0;
  int exp_tbl [16];
  int hit_count = 0;
  int last_tgt, last_off, last_size, last_write;
  logic [31:0] last_wdata;
  int wait_cnt [4];

  always #2 clk = ~clk;

  page_slot_router #(.PAGE_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_offset(cfg_offset),
    .cfg_length(cfg_length), .cfg_target(cfg_target), .cfg_error(cfg_error),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_valid(dev_valid), .dev_write(dev_write), .dev_offset(dev_offset),
    .dev_size(dev_size), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  function automatic logic [31:0] dev_data(int t, int off, int sz);
    return 32'hA500_0000 ^ (t << 24) ^ (off << 8) ^ sz;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device models: random stall, then a one-cycle ack with data
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (dev_ack[i]) begin
        dev_ack[i] = 1'b0;
      end else if (dev_valid[i]) begin
        if (wait_cnt[i] == 0) begin
          dev_ack[i] = 1'b1;
          dev_rdata[i*32 +: 32] = dev_data(i, int'(dev_offset), int'(dev_size));
          last_tgt   = i;
          last_off   = int'(dev_offset);
          last_size  = int'(dev_size);
          last_write = int'(dev_write);
          last_wdata = dev_wdata;
          hit_count++;
          wait_cnt[i] = $urandom % 4;
        end else begin
          wait_cnt[i]--;
        end
      end
    end
  end

  task automatic do_cfg(int off, int len, int tgt);
    bit bad;
    int n, busy;
    bad = (off + len > 4096) || (tgt > SINK);
    n = (bad || len == 0) ? 0 : (((off + len - 1) >> 8) - (off >> 8) + 1);
    @(negedge clk);
    cfg_valid  = 1'b1;
    cfg_offset = 12'(off);
    cfg_length = 13'(len);
    cfg_target = 3'(tgt);
    req_valid  = 1'b1;
    req_addr   = BASE;
    #1;
    chk(req_ready == 1'b0, "R11 cfg beats access", req_ready, 0);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    if (bad) chk(cfg_error == 1'b1, "R5 refused registration error", cfg_error, 1);
    else     chk(cfg_error == 1'b0, "R6 accepted registration no error", cfg_error, 0);
    busy = 0;
    while (!cfg_ready && busy < 40) begin
      if (req_ready) chk(1'b0, "R9 req_ready low during walk", req_ready, 0);
      busy++;
      @(negedge clk);
    end
    chk(busy == n, "R9 walk cycles per slot", busy, n);
    if (!bad) for (int s = off >> 8; s < (off >> 8) + n; s++) exp_tbl[s] = tgt;
  endtask

  task automatic do_acc(int rel, bit wr, int sz, logic [31:0] wd);
    int t, h0, cyc;
    logic [31:0] expd;
    t = exp_tbl[(rel >> 8) & 15];
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = BASE + 32'(rel);
    req_write = wr;
    req_size  = 2'(sz);
    req_wdata = wd;
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    h0 = hit_count;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (t == SINK) begin
      chk(rsp_valid == 1'b1, "R8 sink responds next cycle", rsp_valid, 1);
      chk(rsp_rdata == 32'h0, "R8 sink data zero", rsp_rdata, 0);
      chk(dev_valid == 4'h0 && hit_count == h0, "R8 no device touched", dev_valid, 0);
    end else begin
      chk(dev_valid == 4'(1 << t), "R2 routed to bound target", dev_valid, 1 << t);
      cyc = 0;
      while (!rsp_valid && cyc < 50) begin
        if (req_ready) chk(1'b0, "R10 busy while outstanding", req_ready, 0);
        cyc++;
        @(negedge clk);
      end
      expd = wr ? 32'h0 : dev_data(t, rel, sz);
      chk(rsp_valid == 1'b1, "R10 response arrives", rsp_valid, 1);
      chk(last_tgt == t, "R2 target", last_tgt, t);
      chk(last_off == rel, "R3 page-relative offset", last_off, rel);
      chk(last_size == sz && last_write == int'(wr), "R3 size and direction",
          last_size, sz);
      if (wr) chk(last_wdata == wd, "R3 write data", last_wdata, wd);
      chk(rsp_rdata == expd, "R10 response data", rsp_rdata, expd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_offset = '0; cfg_length = '0; cfg_target = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_size = '0; req_wdata = '0;
    dev_ack = '0; dev_rdata = '0;
    for (int i = 0; i < 4; i++) wait_cnt[i] = 0;
    for (int s = 0; s < 16; s++) exp_tbl[s] = SINK;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_ready && req_ready, "R1 ready after reset", {cfg_ready, req_ready}, 3);
    chk(!rsp_valid && !cfg_error && dev_valid == 4'h0, "R1 outputs idle",
        {rsp_valid, cfg_error, dev_valid}, 0);
    // R1 / R8: empty table
    do_acc(12'h000, 1'b0, 2, 0);
    do_acc(12'hFFC, 1'b0, 2, 0);
    do_acc(12'h344, 1'b1, 0, 32'hDEAD_BEEF);
    // R4: two whole slots, probe edges
    do_cfg(12'h100, 12'h200, 1);
    do_acc(12'h100, 1'b0, 0, 0);
    do_acc(12'h2FF, 1'b1, 0, 32'h11);
    do_acc(12'h300, 1'b0, 1, 0);
    do_acc(12'h0FF, 1'b0, 0, 0);
    // R4: small range straddling a boundary
    do_cfg(12'h3F0, 12'h020, 2);
    do_acc(12'h300, 1'b0, 2, 0);
    do_acc(12'h4FE, 1'b1, 1, 32'hCAFE);
    do_acc(12'h500, 1'b0, 2, 0);
    // R5: exact page end accepted, one byte over refused
    do_cfg(12'hF00, 13'h100, 3);
    do_acc(12'hFFF, 1'b0, 0, 0);
    do_cfg(12'hF01, 13'h100, 0);
    do_acc(12'hF80, 1'b0, 2, 0);
    do_cfg(12'h000, 13'h100, 5);
    do_acc(12'h010, 1'b0, 2, 0);
    // R6: zero length
    do_cfg(12'h100, 13'h0, 0);
    do_acc(12'h104, 1'b0, 2, 0);
    // R7: bind all, then unbind one slot
    do_cfg(12'h000, 13'h1000, 0);
    do_cfg(12'h500, 13'h100, SINK);
    do_acc(12'h5AB, 1'b0, 0, 0);
    do_acc(12'h4AB, 1'b1, 2, 32'h1234_5678);
    do_acc(12'h6AB, 1'b0, 1, 0);
    // random mix
    for (int k = 0; k < 300; k++) begin
      if (($urandom % 5) == 0)
        do_cfg($urandom % 4096, $urandom % 1400, $urandom % 6);
      else
        do_acc($urandom % 4096, 1'($urandom % 2), $urandom % 3, $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule